// File: doc/BRIEF.md
# Open-Bus Latching Read Front End

This block sits in front of the main bus of a 24-bit byte-addressed, 16-bit-data system. It accepts one read at a time from either the CPU (word or byte) or the video DMA engine, decodes the address, fetches from the cartridge, main-RAM or sound-memory port, and returns the data. A single 16-bit register holds the value last seen on the bus. Reads that hit nothing return that value, and it also fills the unused bits of the status and bus-acknowledge registers.

Some DMA sources deliver their data one access late. For each half of the cartridge space, a configuration bit can enable a delayed mode. In that mode a DMA read returns the bus register as it stood and then stores the freshly fetched word. The first read of a transfer therefore yields the prior bus value, and every later read yields the word at the previous address.

Backing memories are synchronous word or byte ports: the request and address are sampled at one clock edge and the data is valid for the next edge.

Top module: `obus_read_front`

## Requirements
- R1: After reset the bus register is zero, `ready_o` is high and `rsp_valid_o` is low, so a first DMA read from an unmapped address returns 0x0000.
- R2: `req_kind_i` encodes 0 = CPU word, 1 = CPU byte, 2 or 3 = DMA word. A request is accepted on a rising edge while `ready_o` is high. `ready_o` is then low for one cycle, and `rsp_valid_o` pulses high for exactly one cycle after the following edge. No memory port is requested while a read is in flight.
- R3: For DMA and CPU reads, 0x000000–0x3FFFFF requests the cartridge port with word address `addr[21:1]`, and 0xE00000–0xFFFFFF requests the RAM port with word index `addr[15:1]`. At most one port is requested per read.
- R4: A DMA read from any other address returns the bus register and leaves it unchanged.
- R5: A DMA read from a mapped region that is not delayed returns the fetched word and stores it in the bus register.
- R6: `dly_en_i[0]` delays 0x000000–0x1FFFFF and `dly_en_i[1]` delays 0x200000–0x3FFFFF. A delayed DMA read returns the prior bus register and stores the fetched word.
- R7: Every CPU word read stores its result in the bus register. A CPU word read from an unmapped address returns 0xFFFF.
- R8: A CPU byte read returns the byte in `rsp_data_o[7:0]` with the upper byte zero. An even address selects bits 15:8 of the word. The byte replaces bits 15:8 of the bus register and bits 7:0 are kept. An unmapped byte read returns 0xFF.
- R9: A CPU read at 0xC00004–0xC00007 returns a word whose bits 15:10 come from the bus register and whose bits 9:0 come from `status_i`.
- R10: A CPU read at 0xA11100–0xA11101 returns a word with bit 8 = `busack_i`, bit 0 = 0, and all other bits from the bus register.
- R11: CPU reads in 0xA00000–0xA0FFFF depend on `snd_grant_i`. While it is high, the sound port is requested at byte address `addr[15:0]`; a word read returns that byte in both halves and a byte read returns the byte. While it is low, no port is requested; a word read returns {bus[15:8], 0x00} and a byte read returns bus[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| req_kind_i | input | 2 | Request kind: CPU word, CPU byte, DMA |
| req_addr_i | input | 24 | Byte address |
| ready_o | output | 1 | Ready to accept a request |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_data_o | output | 16 | Response data |
| dly_en_i | input | 2 | Delayed-DMA enable per cartridge half |
| snd_grant_i | input | 1 | Sound-CPU bus granted |
| status_i | input | 10 | Low status bits |
| busack_i | input | 1 | Bus-acknowledge flag |
| cart_req_o | output | 1 | Cartridge port request |
| cart_addr_o | output | 21 | Cartridge word address |
| cart_rdata_i | input | 16 | Cartridge read data |
| ram_req_o | output | 1 | Main RAM port request |
| ram_addr_o | output | 15 | Main RAM word index |
| ram_rdata_i | input | 16 | Main RAM read data |
| snd_req_o | output | 1 | Sound memory request |
| snd_addr_o | output | 16 | Sound memory byte address |
| snd_rdata_i | input | 8 | Sound memory read data |

## Verification
The assertions check the following on every cycle:
- the accept-to-response timing and the exclusivity of the port requests;
- that an unmapped DMA read returns the bus register without changing it;
- that a delayed read returns the prior register value;
- that a byte read never touches the low register byte;
- that status bits 15:10 carry the register.

Only the bench's scenarios can show the ordering effects. These include the first delayed read yielding the value left by an earlier CPU read, and each following read yielding the previous address's word. They also include how CPU byte and word reads, sound-bus grant changes and status merges shape later unmapped reads through the shared register.

// File: rtl/obus_pkg.sv
package obus_pkg;
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned BYTE_W    = DATA_W / 2;
  localparam int unsigned CART_WA_W = 21;
  localparam int unsigned RAM_WA_W  = 15;
  localparam int unsigned SND_A_W   = 16;
  localparam int unsigned STAT_W    = 10;
  localparam int unsigned N_DLY     = 2;

  typedef enum logic [1:0] {K_WORD = 2'd0, K_BYTE = 2'd1, K_DMA = 2'd2} kind_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_CART0, RG_CART1, RG_RAM, RG_SND, RG_STAT, RG_BACK
  } region_e;
endpackage

// File: rtl/obus_decode.sv
module obus_decode
  import obus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_dma_i,
  output region_e           region_o
);
  always_comb begin
    region_o = RG_NONE;
    if (addr_i[23:22] == 2'b00)         region_o = addr_i[21] ? RG_CART1 : RG_CART0;
    else if (addr_i[23:21] == 3'b111)   region_o = RG_RAM;
    else if (!is_dma_i) begin
      if (addr_i[23:16] == 8'hA0)       region_o = RG_SND;
      else if (addr_i[23:2] == 22'h300001) region_o = RG_STAT;
      else if (addr_i[23:1] == 23'h508880) region_o = RG_BACK;
    end
  end
endmodule

// File: rtl/obus_merge.sv
module obus_merge
  import obus_pkg::*;
(
  input  kind_e             kind_i,
  input  region_e           region_i,
  input  logic              addr0_i,
  input  logic              grant_i,
  input  logic [N_DLY-1:0]  dly_en_i,
  input  logic [DATA_W-1:0] cart_rdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [BYTE_W-1:0] snd_rdata_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              busack_i,
  input  logic [DATA_W-1:0] latch_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] latch_o
);
  logic [DATA_W-1:0] word_v;
  logic [BYTE_W-1:0] byte_v;
  logic              delayed;
  logic              mapped_dma;

  always_comb begin
    unique case (region_i)
      RG_CART0, RG_CART1: word_v = cart_rdata_i;
      RG_RAM:             word_v = ram_rdata_i;
      RG_SND:             word_v = grant_i ? {snd_rdata_i, snd_rdata_i}
                                           : {latch_i[15:8], 8'h00};
      RG_STAT:            word_v = {latch_i[15:10], status_i};
      RG_BACK:            word_v = {latch_i[15:9], busack_i, latch_i[7:1], 1'b0};
      default:            word_v = '1;
    endcase
  end

  always_comb begin
    if (region_i == RG_SND) byte_v = grant_i ? snd_rdata_i : latch_i[15:8];
    else                    byte_v = addr0_i ? word_v[7:0] : word_v[15:8];
  end

  assign mapped_dma = (region_i == RG_CART0) || (region_i == RG_CART1) || (region_i == RG_RAM);
  assign delayed    = ((region_i == RG_CART0) && dly_en_i[0]) ||
                      ((region_i == RG_CART1) && dly_en_i[1]);

  always_comb begin
    unique case (kind_i)
      K_DMA: begin
        if (!mapped_dma) begin
          data_o  = latch_i;
          latch_o = latch_i;
        end else begin
          data_o  = delayed ? latch_i : word_v;
          latch_o = word_v;
        end
      end
      K_BYTE: begin
        data_o  = {{BYTE_W{1'b0}}, byte_v};
        latch_o = {byte_v, latch_i[7:0]};
      end
      default: begin
        data_o  = word_v;
        latch_o = word_v;
      end
    endcase
  end
endmodule

// File: rtl/obus_read_front.sv
module obus_read_front
  import obus_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           req_kind_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 ready_o,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_data_o,
  input  logic [N_DLY-1:0]     dly_en_i,
  input  logic                 snd_grant_i,
  input  logic [STAT_W-1:0]    status_i,
  input  logic                 busack_i,
  output logic                 cart_req_o,
  output logic [CART_WA_W-1:0] cart_addr_o,
  input  logic [DATA_W-1:0]    cart_rdata_i,
  output logic                 ram_req_o,
  output logic [RAM_WA_W-1:0]  ram_addr_o,
  input  logic [DATA_W-1:0]    ram_rdata_i,
  output logic                 snd_req_o,
  output logic [SND_A_W-1:0]   snd_addr_o,
  input  logic [BYTE_W-1:0]    snd_rdata_i
);
  kind_e             kind_in, kind_q;
  region_e           region_in, region_q;
  logic              busy_q, addr0_q, grant_q, accept;
  logic [N_DLY-1:0]  dly_q;
  logic [DATA_W-1:0] latch_q, latch_nxt, data_nxt;

  assign kind_in = req_kind_i[1] ? K_DMA : kind_e'(req_kind_i);
  assign ready_o = !busy_q;
  assign accept  = req_i && !busy_q;

  obus_decode u_decode (
    .addr_i  (req_addr_i),
    .is_dma_i(kind_in == K_DMA),
    .region_o(region_in)
  );

  assign cart_req_o  = accept && ((region_in == RG_CART0) || (region_in == RG_CART1));
  assign ram_req_o   = accept && (region_in == RG_RAM);
  assign snd_req_o   = accept && (region_in == RG_SND) && snd_grant_i;
  assign cart_addr_o = req_addr_i[21:1];
  assign ram_addr_o  = req_addr_i[15:1];
  assign snd_addr_o  = req_addr_i[15:0];

  obus_merge u_merge (
    .kind_i      (kind_q),
    .region_i    (region_q),
    .addr0_i     (addr0_q),
    .grant_i     (grant_q),
    .dly_en_i    (dly_q),
    .cart_rdata_i(cart_rdata_i),
    .ram_rdata_i (ram_rdata_i),
    .snd_rdata_i (snd_rdata_i),
    .status_i    (status_i),
    .busack_i    (busack_i),
    .latch_i     (latch_q),
    .data_o      (data_nxt),
    .latch_o     (latch_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      kind_q      <= K_WORD;
      region_q    <= RG_NONE;
      addr0_q     <= 1'b0;
      grant_q     <= 1'b0;
      dly_q       <= '0;
      latch_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= busy_q;
      if (accept) begin
        busy_q   <= 1'b1;
        kind_q   <= kind_in;
        region_q <= region_in;
        addr0_q  <= req_addr_i[0];
        grant_q  <= snd_grant_i;
        dly_q    <= dly_en_i;
      end else if (busy_q) begin
        busy_q     <= 1'b0;
        latch_q    <= latch_nxt;
        rsp_data_o <= data_nxt;
      end
    end
  end

  // R2: one read in flight, response on the second edge after acceptance
  p_rsp_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o ##1 rsp_valid_o);
  p_no_port_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !(cart_req_o || ram_req_o || snd_req_o));
  p_port_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cart_req_o, ram_req_o, snd_req_o}));
  p_dma_unmapped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && kind_q == K_DMA && region_q == RG_NONE)
    |=> (rsp_data_o == $past(latch_q)) && $stable(latch_q));
  p_dly_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && kind_q == K_DMA &&
     ((region_q == RG_CART0 && dly_q[0]) || (region_q == RG_CART1 && dly_q[1])))
    |=> (rsp_data_o == $past(latch_q)) && (latch_q == $past(cart_rdata_i)));
  p_byte_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && kind_q == K_BYTE)
    |=> (latch_q[7:0] == $past(latch_q[7:0])) && (rsp_data_o[15:8] == 8'h00));
  p_stat_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && kind_q == K_WORD && region_q == RG_STAT)
    |=> rsp_data_o[15:10] == $past(latch_q[15:10]));
endmodule

// File: tb/obus_read_front_bench.sv
`timescale 1ns/1ps
module obus_read_front_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [23:0] addr = '0;
  logic        ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [1:0]  dly_en = 2'b00;
  logic        grant = 1'b0;
  logic [9:0]  status = 10'h000;
  logic        busack = 1'b0;
  logic        cart_req, ram_req, snd_req;
  logic [20:0] cart_addr;
  logic [14:0] ram_addr;
  logic [15:0] snd_addr;
  logic [15:0] cart_rdata = '0, ram_rdata = '0;
  logic [7:0]  snd_rdata = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_latch = '0;

  always #2.5 clk = ~clk;

  obus_read_front u_obus_read_front (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_kind_i(kind), .req_addr_i(addr),
    .ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .dly_en_i(dly_en), .snd_grant_i(grant), .status_i(status), .busack_i(busack),
    .cart_req_o(cart_req), .cart_addr_o(cart_addr), .cart_rdata_i(cart_rdata),
    .ram_req_o(ram_req), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata),
    .snd_req_o(snd_req), .snd_addr_o(snd_addr), .snd_rdata_i(snd_rdata)
  );

  function automatic logic [15:0] cart_fn(input logic [20:0] wa);
    return wa[15:0] ^ {wa[20:16], 11'h2A5};
  endfunction
  function automatic logic [15:0] ram_fn(input logic [14:0] wa);
    return {wa[7:0], wa[14:7]} ^ 16'h3C69;
  endfunction
  function automatic logic [7:0] snd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h96;
  endfunction

  always_ff @(posedge clk) begin
    if (cart_req) cart_rdata <= cart_fn(cart_addr);
    if (ram_req)  ram_rdata  <= ram_fn(ram_addr);
    if (snd_req)  snd_rdata  <= snd_fn(snd_addr);
  end

  // 0 none,1 cart lo,2 cart hi,3 ram,4 snd,5 status,6 busack
  function automatic int reg_of(input logic [1:0] k, input logic [23:0] a);
    if (a[23:22] == 2'b00) return a[21] ? 2 : 1;
    if (a[23:21] == 3'b111) return 3;
    if (k[1]) return 0;
    if (a[23:16] == 8'hA0) return 4;
    if (a >= 24'hC00004 && a <= 24'hC00007) return 5;
    if (a == 24'hA11100 || a == 24'hA11101) return 6;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_model(input logic [1:0] k, input logic [23:0] a,
                           output logic [15:0] d, output string tag);
    int r = reg_of(k, a);
    logic [15:0] w;
    logic [7:0] b;
    case (r)
      1, 2: w = cart_fn(a[21:1]);
      3: w = ram_fn(a[15:1]);
      4: w = grant ? {snd_fn(a[15:0]), snd_fn(a[15:0])} : {exp_latch[15:8], 8'h00};
      5: w = {exp_latch[15:10], status};
      6: w = {exp_latch[15:9], busack, exp_latch[7:1], 1'b0};
      default: w = 16'hFFFF;
    endcase
    if (k[1]) begin
      if (r == 0) begin d = exp_latch; tag = "R4"; end
      else if ((r == 1 && dly_en[0]) || (r == 2 && dly_en[1])) begin
        d = exp_latch; exp_latch = w; tag = "R6";
      end else begin d = w; exp_latch = w; tag = "R5"; end
    end else if (k == 2'd1) begin
      if (r == 4) b = grant ? snd_fn(a[15:0]) : exp_latch[15:8];
      else b = a[0] ? w[7:0] : w[15:8];
      d = {8'h00, b}; exp_latch = {b, exp_latch[7:0]};
      tag = (r == 4) ? "R11" : "R8";
    end else begin
      d = w; exp_latch = w;
      case (r) 4: tag = "R11"; 5: tag = "R9"; 6: tag = "R10"; default: tag = "R7"; endcase
    end
  endtask

  task automatic do_read(input logic [1:0] k, input logic [23:0] a);
    logic [15:0] exp;
    string tag;
    int r = reg_of(k, a);
    bit ec, er, es, ok;
    @(negedge clk);
    req = 1'b1; kind = k; addr = a;
    #1;
    ec = (r == 1 || r == 2); er = (r == 3); es = (r == 4) && grant;
    ok = (cart_req == ec) && (ram_req == er) && (snd_req == es);
    if (ec) ok = ok && (cart_addr == a[21:1]);
    if (er) ok = ok && (ram_addr == a[15:1]);
    if (es) ok = ok && (snd_addr == a[15:0]);
    chk(ok, (r == 4) ? "R11" : "R3", {13'h0, cart_req, ram_req, snd_req}, {13'h0, ec, er, es});
    ref_model(k, a, exp, tag);
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    chk(!ready && !rsp_valid, "R2", {14'h0, ready, rsp_valid}, 16'h0);
    @(negedge clk);
    chk(rsp_valid, "R2", {15'h0, rsp_valid}, 16'h1);
    chk(rsp_data == exp, tag, rsp_data, exp);
    @(negedge clk);
    chk(!rsp_valid && ready, "R2", {14'h0, ready, rsp_valid}, 16'h2);
  endtask

  function automatic logic [23:0] gen_addr(input int sel, input logic [31:0] r);
    case (sel)
      0: return {3'b000, r[20:0]};
      1: return {3'b001, r[20:0]};
      2: return {3'b111, r[20:0]};
      3: return {8'hA0, r[15:0]};
      4: return {22'h300001, r[1:0]};
      5: return {23'h508880, r[0]};
      default: return {8'h80, r[15:0]};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251107));
    repeat (3) @(negedge clk);
    chk(ready && !rsp_valid && rsp_data == 16'h0, "R1", rsp_data, 16'h0);
    rst_n = 1'b1;
    // R1: first unmapped DMA read sees the cleared register
    do_read(2'd2, 24'h500000);
    // R7: unmapped CPU word read
    do_read(2'd0, 24'h800010);
    // R4: DMA unmapped now returns 0xFFFF from the register
    do_read(2'd2, 24'h400000);
    // R6: delayed transfer from upper cartridge half; prime register from RAM
    dly_en = 2'b10;
    do_read(2'd0, 24'hE01234);
    for (int i = 0; i < 4; i++) do_read(2'd2, 24'h200000 + 24'(2 * i));
    // R5: lower half not delayed, RAM never delayed
    do_read(2'd2, 24'h000100);
    do_read(2'd3, 24'hFF0002);
    // R6: lower half delayed
    dly_en = 2'b01;
    do_read(2'd2, 24'h000200);
    do_read(2'd2, 24'h000202);
    // R8: byte reads, even then odd
    do_read(2'd1, 24'hE00010);
    do_read(2'd1, 24'hE00011);
    do_read(2'd1, 24'h900001);
    // R9, R10
    status = 10'h2B7; busack = 1'b1;
    do_read(2'd0, 24'hC00004);
    do_read(2'd0, 24'hA11100);
    do_read(2'd1, 24'hA11101);
    // R11: sound window not granted, then granted
    grant = 1'b0;
    do_read(2'd0, 24'hA00040);
    do_read(2'd1, 24'hA00041);
    grant = 1'b1;
    do_read(2'd0, 24'hA00042);
    do_read(2'd1, 24'hA01FFF);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      int k = $urandom % 4;
      if (($urandom % 8) == 0) dly_en = 2'($urandom);
      if (($urandom % 8) == 0) grant = 1'($urandom);
      if (($urandom % 8) == 0) status = 10'($urandom);
      if (($urandom % 8) == 0) busack = 1'($urandom);
      do_read(2'(k), gen_addr($urandom % 7, rv));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule